// File: doc/BRIEF.md
# Base-16 Floating-Point Adder/Subtractor

This block adds or subtracts two single-precision numbers in a radix-16 format. Each 32-bit word holds a sign in bit 31, a 7-bit exponent biased by 64 in bits 30..24, and a fraction of six hex digits in bits 23..0. The value of a word is (-1)^sign x 0.fraction x 16^(exponent-64). The caller supplies an accumulator word, a second operand word and an add/subtract select. The caller pulses start, and a done pulse later marks a valid result word and its overflow and underflow flags.

Internally the fractions become two's-complement values with a carry digit above them and a guard digit below them. The operand with the smaller exponent is aligned one hex digit per clock. The two values are summed. The sum is converted back to sign and magnitude and normalized one hex digit per clock. Latency therefore depends on the data: one cycle for the zero shortcuts, and up to about sixteen cycles in the worst case.

Top module: `hexfp_addsub`

## Requirements
- R1: When the second operand's fraction (bits 23..0) is zero, the result is the accumulator word unchanged, whatever the select, with both flags low, and done follows the start by one clock.
- R2: When R1 does not apply and the accumulator's fraction is zero, the result is the second operand word, with bit 31 inverted when subtracting.
- R3: Subtraction (sub_i=1) gives exactly the result of an addition in which bit 31 of the second operand is inverted.
- R4: If the exponents differ by 6 or less, the operand with the smaller exponent is shifted right as a two's-complement value, one hex digit per clock, and its exponent is incremented until the exponents match. Only the last digit shifted out is kept, as one guard digit. Because the shift is arithmetic, a negative operand rounds toward minus infinity.
- R5: If the exponents differ by more than 6, the smaller operand counts as zero and the larger exponent becomes the result exponent.
- R6: A sum that is zero, guard digit included, gives the all-zero word with both flags low.
- R7: A negative sum is negated back to a magnitude, guard digit included, and the result sign bit is 1.
- R8: A sum that carries into a seventh hex digit is shifted right by one digit and its exponent is incremented. If the exponent would pass 127, the result is the all-zero word with ovf_o high.
- R9: While the top fraction digit (bits 23..20 of the result) is zero, the fraction is shifted left by one digit and the exponent is decremented. The first such shift fills the low digit from the guard digit, and later shifts fill it with zero. The guard digit is then dropped and the fraction is truncated.
- R10: If another left shift is needed while the exponent is 0, the result is the all-zero word with unf_o high.
- R11: done_o is high for exactly one clock per accepted start. The result and flags hold until the next completion. A start that arrives while an operation is in progress is ignored.
- R12: After reset, done_o, ovf_o and unf_o are low and result_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| sub_i | input | 1 | 1 selects accumulator minus operand |
| acc_i | input | 32 | Accumulator word |
| opd_i | input | 32 | Second operand word |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Result word |
| ovf_o | output | 1 | Exponent overflow on the last operation |
| unf_o | output | 1 | Exponent underflow on the last operation |

## Verification
The bench targets several corner cases. At an exponent gap of exactly 6 versus 7, a wrong threshold would either drop a value that still counts or keep one that should vanish. A subtraction that borrows across the guard digit shows whether the single guard digit is refilled, and whether a negative operand is truncated toward minus infinity rather than toward zero. Sums that cancel to zero, carry out at exponent 127, or need a left shift at exponent 0 show whether canonical zeros and the right flag come out. A structured sweep over signs, exponent gaps from 0 to 7 and extreme fractions compares every result with an arithmetic model, and a start issued mid-operation must not disturb the result.

// File: rtl/hexfp_pkg.sv
package hexfp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_NORM  = 2'd2
  } hexfp_state_e;
endpackage

// File: rtl/hexfp_unpack.sv
// Splits a word into exponent, zero flag and a two's-complement working
// fraction laid out as {carry digit, six fraction digits, guard digit}.
module hexfp_unpack #(
  parameter int EXP_W  = 7,
  parameter int DIGITS = 6,
  localparam int FRAC_W = 4 * DIGITS,
  localparam int MW     = FRAC_W + 8,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              zero_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [MW-1:0]     mant_o
);
  logic [FRAC_W-1:0] frac;
  logic [MW-1:0]     mag;

  assign frac   = word_i[FRAC_W-1:0];
  assign exp_o  = word_i[WORD_W-2:FRAC_W];
  assign zero_o = (frac == '0);
  assign mag    = {4'b0000, frac, 4'b0000};
  assign mant_o = word_i[WORD_W-1] ? (-mag) : mag;
endmodule

// File: rtl/hexfp_align_step.sv
// One alignment step: the operand with the smaller exponent moves one hex
// digit right, or is dropped when the gap exceeds MAX_SHIFT.
module hexfp_align_step #(
  parameter int EXP_W     = 7,
  parameter int MW        = 32,
  parameter int MAX_SHIFT = 6
) (
  input  logic [EXP_W-1:0] ea_i,
  input  logic [EXP_W-1:0] eb_i,
  input  logic [MW-1:0]    ma_i,
  input  logic [MW-1:0]    mb_i,
  output logic             eq_o,
  output logic [EXP_W-1:0] ea_o,
  output logic [EXP_W-1:0] eb_o,
  output logic [MW-1:0]    ma_o,
  output logic [MW-1:0]    mb_o
);
  localparam logic [EXP_W-1:0] MAX_GAP = EXP_W'(MAX_SHIFT);
  localparam logic [EXP_W-1:0] E_ONE   = EXP_W'(1);

  logic [EXP_W-1:0] gap_ab;
  logic [EXP_W-1:0] gap_ba;

  assign gap_ab = ea_i - eb_i;
  assign gap_ba = eb_i - ea_i;
  assign eq_o   = (ea_i == eb_i);

  always_comb begin
    ea_o = ea_i;
    eb_o = eb_i;
    ma_o = ma_i;
    mb_o = mb_i;
    if (ea_i < eb_i) begin
      if (gap_ba > MAX_GAP) begin
        ma_o = '0;
        ea_o = eb_i;
      end else begin
        ma_o = $signed(ma_i) >>> 4;
        ea_o = ea_i + E_ONE;
      end
    end else if (eb_i < ea_i) begin
      if (gap_ab > MAX_GAP) begin
        mb_o = '0;
        eb_o = ea_i;
      end else begin
        mb_o = $signed(mb_i) >>> 4;
        eb_o = eb_i + E_ONE;
      end
    end
  end
endmodule

// File: rtl/hexfp_norm_step.sv
// One normalization step on a magnitude {carry digit, fraction, guard}.
module hexfp_norm_step #(
  parameter int EXP_W = 7,
  parameter int MW    = 32
) (
  input  logic [MW-1:0]    mag_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [MW-1:0]    mag_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             fin_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam logic [EXP_W-1:0] E_ONE = EXP_W'(1);

  logic carry_dig;
  logic top_zero;

  assign carry_dig = (mag_i[MW-1 -: 4] != 4'h0);
  assign top_zero  = (mag_i[MW-5 -: 4] == 4'h0);

  always_comb begin
    mag_o = mag_i;
    exp_o = exp_i;
    fin_o = 1'b0;
    ovf_o = 1'b0;
    unf_o = 1'b0;
    if (carry_dig) begin
      mag_o = mag_i >> 4;
      if (exp_i == {EXP_W{1'b1}}) ovf_o = 1'b1;
      else                        exp_o = exp_i + E_ONE;
    end else if (top_zero) begin
      if (exp_i == '0) unf_o = 1'b1;
      else begin
        mag_o = mag_i << 4;
        exp_o = exp_i - E_ONE;
      end
    end else begin
      fin_o = 1'b1;
    end
  end
endmodule

// File: rtl/hexfp_addsub.sv
module hexfp_addsub #(
  parameter int EXP_W     = 7,
  parameter int DIGITS    = 6,
  parameter int MAX_SHIFT = 6,
  localparam int FRAC_W = 4 * DIGITS,
  localparam int MW     = FRAC_W + 8,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              sub_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] opd_i,
  output logic              done_o,
  output logic [WORD_W-1:0] result_o,
  output logic              ovf_o,
  output logic              unf_o
);
  import hexfp_pkg::*;

  hexfp_state_e state_q;

  logic [WORD_W-1:0] opd_eff;
  logic [WORD_W-1:0] word_in [2];
  logic              zero_in [2];
  logic [EXP_W-1:0]  exp_in  [2];
  logic [MW-1:0]     mant_in [2];

  logic [EXP_W-1:0]  ea_q, eb_q;
  logic [MW-1:0]     ma_q, mb_q;
  logic [MW-1:0]     mag_q;
  logic              sign_q;
  logic              done_q, ovf_q, unf_q;
  logic [WORD_W-1:0] result_q;

  // subtraction: invert the operand sign, then add
  assign opd_eff    = {opd_i[WORD_W-1] ^ sub_i, opd_i[WORD_W-2:0]};
  assign word_in[0] = acc_i;
  assign word_in[1] = opd_eff;

  for (genvar k = 0; k < 2; k++) begin : g_unpack
    hexfp_unpack #(.EXP_W(EXP_W), .DIGITS(DIGITS)) u_unpack (
      .word_i (word_in[k]),
      .zero_o (zero_in[k]),
      .exp_o  (exp_in[k]),
      .mant_o (mant_in[k])
    );
  end

  logic             al_eq;
  logic [EXP_W-1:0] al_ea, al_eb;
  logic [MW-1:0]    al_ma, al_mb;

  hexfp_align_step #(.EXP_W(EXP_W), .MW(MW), .MAX_SHIFT(MAX_SHIFT)) u_align (
    .ea_i (ea_q),
    .eb_i (eb_q),
    .ma_i (ma_q),
    .mb_i (mb_q),
    .eq_o (al_eq),
    .ea_o (al_ea),
    .eb_o (al_eb),
    .ma_o (al_ma),
    .mb_o (al_mb)
  );

  logic [MW-1:0] sum;
  logic          sum_neg;
  logic [MW-1:0] sum_abs;

  assign sum     = ma_q + mb_q;
  assign sum_neg = sum[MW-1];
  assign sum_abs = sum_neg ? (-sum) : sum;

  logic [MW-1:0]    nm_mag;
  logic [EXP_W-1:0] nm_exp;
  logic             nm_fin, nm_ovf, nm_unf;

  hexfp_norm_step #(.EXP_W(EXP_W), .MW(MW)) u_norm (
    .mag_i (mag_q),
    .exp_i (ea_q),
    .mag_o (nm_mag),
    .exp_o (nm_exp),
    .fin_o (nm_fin),
    .ovf_o (nm_ovf),
    .unf_o (nm_unf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ea_q     <= '0;
      eb_q     <= '0;
      ma_q     <= '0;
      mb_q     <= '0;
      mag_q    <= '0;
      sign_q   <= 1'b0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (zero_in[1]) begin
              result_q <= acc_i;
              ovf_q    <= 1'b0;
              unf_q    <= 1'b0;
              done_q   <= 1'b1;
            end else if (zero_in[0]) begin
              result_q <= opd_eff;
              ovf_q    <= 1'b0;
              unf_q    <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              ea_q    <= exp_in[0];
              eb_q    <= exp_in[1];
              ma_q    <= mant_in[0];
              mb_q    <= mant_in[1];
              state_q <= ST_ALIGN;
            end
          end
        end
        ST_ALIGN: begin
          if (al_eq) begin
            if (sum == '0) begin
              result_q <= '0;
              ovf_q    <= 1'b0;
              unf_q    <= 1'b0;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              mag_q   <= sum_abs;
              sign_q  <= sum_neg;
              state_q <= ST_NORM;
            end
          end else begin
            ea_q <= al_ea;
            eb_q <= al_eb;
            ma_q <= al_ma;
            mb_q <= al_mb;
          end
        end
        ST_NORM: begin
          if (nm_ovf || nm_unf) begin
            result_q <= '0;
            ovf_q    <= nm_ovf;
            unf_q    <= nm_unf;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (nm_fin) begin
            result_q <= {sign_q, ea_q, mag_q[FRAC_W+3:4]};
            ovf_q    <= 1'b0;
            unf_q    <= 1'b0;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            mag_q <= nm_mag;
            ea_q  <= nm_exp;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign result_o = result_q;
  assign ovf_o    = ovf_q;
  assign unf_o    = unf_q;

  // exponent gap seen by the alignment loop, used only by a check below
  logic [EXP_W-1:0] gap_now;
  assign gap_now = (ea_q > eb_q) ? (ea_q - eb_q) : (eb_q - ea_q);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (state_q == ST_IDLE));

  a_r8_ovf_zero: assert property (@(posedge clk) disable iff (rst)
    (done_o && ovf_o) |-> (result_o == '0 && !unf_o));

  a_r10_unf_zero: assert property (@(posedge clk) disable iff (rst)
    (done_o && unf_o) |-> (result_o == '0 && !ovf_o));

  a_r4_gap_shrinks: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ALIGN && !al_eq) |=> (gap_now < $past(gap_now)));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!done_o && state_q != ST_IDLE) |-> $stable(result_o));
endmodule

// File: tb/sim_hexfp_addsub.sv
module sim_hexfp_addsub;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        sub_i = 1'b0;
  logic [31:0] acc_i = '0;
  logic [31:0] opd_i = '0;
  logic        done_o;
  logic [31:0] result_o;
  logic        ovf_o, unf_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hexfp_addsub u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .sub_i(sub_i),
    .acc_i(acc_i), .opd_i(opd_i), .done_o(done_o),
    .result_o(result_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // arithmetic reference built from the requirements
  function automatic void model(input logic [31:0] a, input logic [31:0] b, input logic sub,
                                output logic [31:0] r, output logic ov, output logic un,
                                output string tag);
    logic [31:0] bb;
    longint va, vb, s, m;
    int ea, eb, e, d;
    logic sg;
    bb = b ^ {sub, 31'b0};
    ov = 1'b0; un = 1'b0; sg = 1'b0;
    if (b[23:0] == 0) begin r = a; tag = "R1"; return; end
    if (a[23:0] == 0) begin r = bb; tag = "R2"; return; end
    ea = int'(a[30:24]); eb = int'(bb[30:24]);
    va = longint'(a[23:0]) * 16;  if (a[31])  va = -va;
    vb = longint'(bb[23:0]) * 16; if (bb[31]) vb = -vb;
    tag = "R4";
    if (eb > ea) begin
      d = eb - ea; e = eb;
      if (d > 6) begin va = 0; tag = "R5"; end else va = va >>> (4 * d);
    end else begin
      d = ea - eb; e = ea;
      if (d > 6) begin vb = 0; tag = "R5"; end else vb = vb >>> (4 * d);
    end
    s = va + vb;
    if (s == 0) begin r = '0; tag = "R6"; return; end
    if (s < 0) begin m = -s; sg = 1'b1; tag = "R7"; end else m = s;
    if (m >= 64'h1000_0000) begin
      m = m >> 4; e++; tag = "R8";
      if (e > 127) begin r = '0; ov = 1'b1; return; end
    end
    while (m < 64'h100_0000) begin
      if (e == 0) begin r = '0; un = 1'b1; tag = "R10"; return; end
      e--; m = m << 4; tag = "R9";
    end
    r = {sg, 7'(e), m[27:4]};
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic sub,
                        output logic [33:0] got, output logic seen);
    @(negedge clk);
    acc_i = a; opd_i = b; sub_i = sub; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int n = 0; n < 64 && !done_o; n++) @(negedge clk);
    seen = done_o;
    got = {ovf_o, unf_o, result_o};
  endtask

  task automatic directed(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic sub, input logic [31:0] er, input logic eo, input logic eu);
    logic [33:0] got;
    logic seen;
    run_op(a, b, sub, got, seen);
    chk({tag, " done"}, {33'b0, seen}, 34'd1);
    chk(tag, got, {eo, eu, er});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [33:0] got;
    logic seen;
    logic [31:0] er;
    logic eo, eu;
    string tg;
    logic [7:0]  aexp [3];
    logic [23:0] afr  [5];
    logic [7:0]  bexp [12];
    logic [23:0] bfr  [3];
    aexp = '{8'd0, 8'd64, 8'd127};
    afr  = '{24'h100000, 24'hFFFFFF, 24'h123456, 24'h000001, 24'h800000};
    bexp = '{8'd0, 8'd1, 8'd5, 8'd6, 8'd7, 8'd58, 8'd64, 8'd65, 8'd70, 8'd71, 8'd120, 8'd127};
    bfr  = '{24'h100000, 24'hFFFFFF, 24'h123456};

    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 done",   {33'b0, done_o}, 34'd0);
    chk("R12 result", {2'b0, result_o}, 34'd0);
    chk("R12 flags",  {32'b0, ovf_o, unf_o}, 34'd0);
    rst = 1'b0;

    directed("R1 zero operand",      32'hC3ABCDEF, 32'h12000000, 1'b1, 32'hC3ABCDEF, 1'b0, 1'b0);
    directed("R2 zero acc sub",      32'h00000000, 32'h41100000, 1'b1, 32'hC1100000, 1'b0, 1'b0);
    directed("R3 sub",               32'h42300000, 32'h41800000, 1'b1, 32'h42280000, 1'b0, 1'b0);
    directed("R3 add negated",       32'h42300000, 32'hC1800000, 1'b0, 32'h42280000, 1'b0, 1'b0);
    directed("R4 R9 guard refill",   32'h41100001, 32'h3C123400, 1'b1, 32'h40FFFFFD, 1'b0, 1'b0);
    directed("R5 gap six kept",      32'h46100000, 32'h40F00000, 1'b1, 32'h45FFFFF1, 1'b0, 1'b0);
    directed("R5 gap seven dropped", 32'h47100000, 32'h40F00000, 1'b1, 32'h47100000, 1'b0, 1'b0);
    directed("R6 cancel",            32'h41123456, 32'h41123456, 1'b1, 32'h00000000, 1'b0, 1'b0);
    directed("R7 negative sum",      32'h41100000, 32'h41200000, 1'b1, 32'hC1100000, 1'b0, 1'b0);
    directed("R8 carry",             32'h41800000, 32'h41A00000, 1'b0, 32'h42120000, 1'b0, 1'b0);
    directed("R8 overflow",          32'h7F800000, 32'h7F800000, 1'b0, 32'h00000000, 1'b1, 1'b0);
    directed("R9 zero fill",         32'h41123456, 32'h41123400, 1'b1, 32'h3D560000, 1'b0, 1'b0);
    directed("R10 underflow",        32'h00100000, 32'h80080000, 1'b0, 32'h00000000, 1'b0, 1'b1);

    // R11: done lasts one clock, result holds, busy start ignored
    run_op(32'h46100000, 32'h40F00000, 1'b1, got, seen);
    @(negedge clk);
    chk("R11 done one clock", {33'b0, done_o}, 34'd0);
    repeat (3) @(negedge clk);
    chk("R11 result held", {ovf_o, unf_o, result_o}, {2'b00, 32'h45FFFFF1});
    @(negedge clk);
    acc_i = 32'h46100000; opd_i = 32'h40F00000; sub_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    acc_i = 32'h41100000; opd_i = 32'h41100000; sub_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int n = 0; n < 64 && !done_o; n++) @(negedge clk);
    chk("R11 busy start ignored", {ovf_o, unf_o, result_o}, {2'b00, 32'h45FFFFF1});
    repeat (20) @(negedge clk);
    chk("R11 no second done", {33'b0, done_o}, 34'd0);

    // sweep over signs, exponent gaps and extreme fractions
    for (int ia = 0; ia < 3; ia++)
      for (int fa = 0; fa < 5; fa++)
        for (int sa = 0; sa < 2; sa++)
          for (int ib = 0; ib < 12; ib++)
            for (int fb = 0; fb < 3; fb++)
              for (int sb = 0; sb < 2; sb++)
                for (int op = 0; op < 2; op++) begin
                  logic [31:0] wa, wb;
                  wa = {sa[0], aexp[ia][6:0], afr[fa]};
                  wb = {sb[0], bexp[ib][6:0], bfr[fb]};
                  if (((ia * 5 + fa + ib * 3 + fb + sa + sb) % 3) == 0) begin
                    model(wa, wb, op[0], er, eo, eu, tg);
                    run_op(wa, wb, op[0], got, seen);
                    chk({tg, " sweep"}, {seen, got[33:32], got[31:0]} & 34'h3FFFFFFFF,
                        {eo, eu, er} | {1'b0, 33'b0});
                  end
                end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule